// File: doc/BRIEF.md
# Programmable Device Bus Timing Controller

This block turns one host access into strobe timing on an external device bus that shares its address and data lines. The host presents a read or write request, the width of the target device (8, 16 or 32 bits) and that device's timing settings. The block then drives an active-low chip select, read strobe and write strobe, and it shows which narrow device cycle is in progress. When the whole access has finished, it returns one done pulse to the host, together with the read word for a read.

Each timed phase lasts its programmed value plus two clocks. Phase values that are too small are raised to the lowest legal value. If a phase that allows wait states is programmed above its minimum, an external active-low ready input holds the last cycle of that phase until the device is ready. If the same phase is programmed at its minimum, the ready input is ignored. A 32-bit host word sent to a narrow device is moved in several device cycles, lowest lane first.

Top module: `dbt_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, dev_cs_n, dev_rd_n and dev_wr_n are high and host_busy and host_done are low.
- R2: An idle block accepts req_valid on a clock edge. From the next cycle, dev_cs_n and host_busy stay low and high respectively until the access ends.
- R3: A write holds dev_wr_n high with dev_cs_n low for max(t_cs2wr,1)+2 cycles. It then drives dev_wr_n low for t_wact+2 cycles in each device cycle.
- R4: A read keeps dev_rd_n low. Its first device cycle lasts max(t_first,1)+2 cycles. If t_first>1, t_next>0 or t_wact>0, the matching phase with dev_ready_n high on its last cycle repeats that last cycle, one clock at a time, until dev_ready_n is sampled low.
- R5: When t_first<=1 (first read cycle), t_next==0 (later read cycles) or t_wact==0 (write-low phase), dev_ready_n has no effect on the length of that phase.
- R6: req_width code 0 means an 8-bit device (4 device cycles), code 1 means a 16-bit device (2 cycles), and codes 2 and 3 mean a 32-bit device (1 cycle). Each read device cycle after the first lasts t_next+2 cycles, and dev_rd_n stays low without a break between cycles.
- R7: In device cycle b of width w bits, a write drives req_wdata[b*w +: w] on dev_wdata[w-1:0] with the upper bits zero. A read stores dev_rdata[w-1:0], sampled on the last clock of that cycle, into host_rdata[b*w +: w].
- R8: Between write device cycles, dev_wr_n is high for g cycles while dev_cs_n stays low. g = t_whigh, raised to at least 1 for 8-bit and 16-bit devices.
- R9: t_cs2wr and t_first values of 0 are treated as 1.
- R10: host_done is high for exactly one cycle: the cycle after the final device cycle ends. In that cycle dev_cs_n is high, host_busy is low, and, for a read, host_rdata holds the assembled word.
- R11: req_valid while host_busy is high is ignored. A request held high is accepted again in the host_done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_width | input | 2 | Device width code (0: 8, 1: 16, 2/3: 32 bits) |
| req_wdata | input | 32 | Host write word |
| t_cs2wr | input | 4 | Chip select to write-strobe phase value |
| t_first | input | 4 | First read data phase value |
| t_next | input | 4 | Later read data phase value |
| t_wact | input | 4 | Write strobe low phase value |
| t_whigh | input | 4 | Write strobe high gap between device cycles |
| dev_ready_n | input | 1 | Device ready, active low |
| dev_rdata | input | 32 | Device read data |
| dev_cs_n | output | 1 | Chip select, active low |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_wdata | output | 32 | Device write data for the current device cycle |
| dev_beat | output | 2 | Index of the current device cycle |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Assembled read word |

## Verification
The assertions assume that the timing settings and the width code stay constant while host_busy is high. They also assume that dev_ready_n is held at a known level on every clock. The stimulus changes settings only after the model reports that the access is complete, and it drives ready from a shift register that is never unknown. Random ready patterns are applied both with phases above their minimum, so that stalls occur, and with phases at their minimum, so that the same patterns must have no effect.

// File: rtl/dbt_pkg.sv
// Shared types and helpers for the device bus timing controller.
// Assumes a 32-bit host word and device widths of 8, 16 or 32 bits.
package dbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_SETUP = 3'd2,
        ST_WACT  = 3'd3,
        ST_WGAP  = 3'd4
    } dbt_state_t;

    localparam logic [1:0] WID_8  = 2'd0;
    localparam logic [1:0] WID_16 = 2'd1;

    // Index of the last device cycle for a width code.
    function automatic logic [1:0] last_beat(input logic [1:0] w);
        case (w)
            WID_8:   return 2'd3;
            WID_16:  return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/dbt_clamp.sv
// Raises timing settings to their legal minimum and flags the phases that
// ignore ready. Assumes the width code has already been latched.
module dbt_clamp #(
    parameter int PW = 4
) (
    input  logic [1:0]    width,
    input  logic [PW-1:0] cs2wr,
    input  logic [PW-1:0] first,
    input  logic [PW-1:0] next,
    input  logic [PW-1:0] wact,
    input  logic [PW-1:0] whigh,
    output logic [PW-1:0] cs2wr_eff,
    output logic [PW-1:0] first_eff,
    output logic [PW-1:0] gap_eff,
    output logic          ign_first,
    output logic          ign_next,
    output logic          ign_wact
);
    import dbt_pkg::*;

    localparam logic [PW-1:0] ONE = PW'(1);

    logic narrow;

    // Minimum values and ready-ignore flags.
    always_comb begin
        narrow    = (width == WID_8) || (width == WID_16);
        cs2wr_eff = (cs2wr < ONE) ? ONE : cs2wr;
        first_eff = (first < ONE) ? ONE : first;
        gap_eff   = (narrow && whigh < ONE) ? ONE : whigh;
        ign_first = (first <= ONE);
        ign_next  = (next == '0);
        ign_wact  = (wact == '0);
    end

endmodule

// File: rtl/dbt_lane.sv
// Places the current device cycle's slice of the host word on the device
// lanes and builds the read word one slice at a time.
// Assumes DW is 32 and the beat index is in range for the width.
module dbt_lane #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    width,
    input  logic [1:0]    beat,
    input  logic [DW-1:0] wd,
    input  logic [DW-1:0] rdev,
    input  logic          cap_en,
    input  logic          clr,
    output logic [DW-1:0] dev_wdata,
    output logic [DW-1:0] rword
);
    import dbt_pkg::*;

    // Write slice for the current device cycle.
    always_comb begin
        case (width)
            WID_8:   dev_wdata = {{(DW-8){1'b0}}, wd[8*beat +: 8]};
            WID_16:  dev_wdata = {{(DW-16){1'b0}}, wd[16*beat[0] +: 16]};
            default: dev_wdata = wd;
        endcase
    end

    // Read word assembly.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rword <= '0;
        end else if (cap_en) begin
            case (width)
                WID_8:   rword[8*beat +: 8]       <= rdev[7:0];
                WID_16:  rword[16*beat[0] +: 16]  <= rdev[15:0];
                default: rword                    <= rdev;
            endcase
        end
    end

endmodule

// File: rtl/dbt_seq.sv
// Phase sequencer: walks through setup, strobe and gap phases and stretches
// the last cycle of a phase while ready is high, unless the phase ignores ready.
// Assumes the timing settings are stable while an access is in progress.
module dbt_seq #(
    parameter int PW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_width,
    input  logic [DW-1:0] req_wdata,
    input  logic          ready_n,
    input  logic [PW-1:0] cs2wr_eff,
    input  logic [PW-1:0] first_eff,
    input  logic [PW-1:0] next,
    input  logic [PW-1:0] wact,
    input  logic [PW-1:0] gap_eff,
    input  logic          ign_first,
    input  logic          ign_next,
    input  logic          ign_wact,
    output logic [1:0]    width_q,
    output logic [DW-1:0] wd_q,
    output logic [1:0]    beat,
    output logic          cap_en,
    output logic          clr,
    output logic          cs_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          busy,
    output logic          done
);
    import dbt_pkg::*;

    localparam int CW = PW + 1;

    dbt_state_t    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] end_val;
    logic          ign;
    logic          at_end;
    logic          step;
    logic          last;

    // Last count and ready policy of the current phase.
    always_comb begin
        end_val = '0;
        ign     = 1'b1;
        case (state)
            ST_READ: begin
                end_val = (beat == 2'd0) ? CW'(first_eff) + CW'(1) : CW'(next) + CW'(1);
                ign     = (beat == 2'd0) ? ign_first : ign_next;
            end
            ST_SETUP: end_val = CW'(cs2wr_eff) + CW'(1);
            ST_WACT: begin
                end_val = CW'(wact) + CW'(1);
                ign     = ign_wact;
            end
            ST_WGAP: end_val = CW'(gap_eff) - CW'(1);
            default: ;
        endcase
        at_end = (cnt == end_val);
        step   = at_end && (ign || !ready_n);
        last   = (beat == last_beat(width_q));
        cap_en = (state == ST_READ) && step;
        clr    = (state == ST_IDLE) && req_valid;
        cs_n   = (state == ST_IDLE);
        busy   = (state != ST_IDLE);
        rd_n   = (state != ST_READ);
        wr_n   = (state != ST_WACT);
    end

    // State, phase counter and device cycle index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            beat    <= '0;
            done    <= 1'b0;
            width_q <= '0;
            wd_q    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    width_q <= req_width;
                    wd_q    <= req_wdata;
                    beat    <= '0;
                    cnt     <= '0;
                    state   <= req_write ? ST_SETUP : ST_READ;
                end
                ST_READ: begin
                    if (!at_end) begin
                        cnt <= cnt + CW'(1);
                    end else if (step) begin
                        cnt <= '0;
                        if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            beat <= beat + 2'd1;
                        end
                    end
                end
                ST_SETUP: begin
                    cnt <= at_end ? '0 : cnt + CW'(1);
                    if (at_end) state <= ST_WACT;
                end
                ST_WACT: begin
                    if (!at_end) begin
                        cnt <= cnt + CW'(1);
                    end else if (step) begin
                        cnt <= '0;
                        if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else if (gap_eff == '0) begin
                            beat <= beat + 2'd1;
                        end else begin
                            state <= ST_WGAP;
                        end
                    end
                end
                ST_WGAP: begin
                    cnt <= at_end ? '0 : cnt + CW'(1);
                    if (at_end) begin
                        state <= ST_WACT;
                        beat  <= beat + 2'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dbt_ctrl.sv
// Top of the device bus timing controller: clamps the settings, sequences
// the strobes and steers the data lanes. Assumes the settings stay unchanged
// while host_busy is high.
module dbt_ctrl #(
    parameter int PW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_width,
    input  logic [DW-1:0] req_wdata,
    input  logic [PW-1:0] t_cs2wr,
    input  logic [PW-1:0] t_first,
    input  logic [PW-1:0] t_next,
    input  logic [PW-1:0] t_wact,
    input  logic [PW-1:0] t_whigh,
    input  logic          dev_ready_n,
    input  logic [DW-1:0] dev_rdata,
    output logic          dev_cs_n,
    output logic          dev_rd_n,
    output logic          dev_wr_n,
    output logic [DW-1:0] dev_wdata,
    output logic [1:0]    dev_beat,
    output logic          host_busy,
    output logic          host_done,
    output logic [DW-1:0] host_rdata
);
    logic [1:0]    width_q;
    logic [DW-1:0] wd_q;
    logic [PW-1:0] cs2wr_eff, first_eff, gap_eff;
    logic          ign_first, ign_next, ign_wact;
    logic          cap_en, clr;

    dbt_clamp #(.PW(PW)) u_clamp (
        .width(width_q), .cs2wr(t_cs2wr), .first(t_first), .next(t_next),
        .wact(t_wact), .whigh(t_whigh), .cs2wr_eff(cs2wr_eff),
        .first_eff(first_eff), .gap_eff(gap_eff), .ign_first(ign_first),
        .ign_next(ign_next), .ign_wact(ign_wact)
    );

    dbt_seq #(.PW(PW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_width(req_width), .req_wdata(req_wdata), .ready_n(dev_ready_n),
        .cs2wr_eff(cs2wr_eff), .first_eff(first_eff), .next(t_next),
        .wact(t_wact), .gap_eff(gap_eff), .ign_first(ign_first),
        .ign_next(ign_next), .ign_wact(ign_wact), .width_q(width_q),
        .wd_q(wd_q), .beat(dev_beat), .cap_en(cap_en), .clr(clr),
        .cs_n(dev_cs_n), .rd_n(dev_rd_n), .wr_n(dev_wr_n),
        .busy(host_busy), .done(host_done)
    );

    dbt_lane #(.DW(DW)) u_lane (
        .clk(clk), .rst_n(rst_n), .width(width_q), .beat(dev_beat),
        .wd(wd_q), .rdev(dev_rdata), .cap_en(cap_en), .clr(clr),
        .dev_wdata(dev_wdata), .rword(host_rdata)
    );

endmodule

// File: rtl/dbt_ctrl_chk.sv
// Protocol checker for the device bus timing controller, bound to the top.
// Assumes settings are stable during an access.
module dbt_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic dev_cs_n,
    input logic dev_rd_n,
    input logic dev_wr_n,
    input logic host_busy,
    input logic host_done
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dev_cs_n && dev_rd_n && dev_wr_n && !host_done));

    assert_busy_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> !dev_cs_n);

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_rd_n && !dev_wr_n));

    assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_n || !dev_wr_n) |-> !dev_cs_n);

    assert_wr_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_wr_n) |-> $past(!dev_cs_n));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (dev_cs_n && !host_busy && $past(host_busy)));

endmodule

bind dbt_ctrl dbt_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n),
    .dev_wr_n(dev_wr_n), .host_busy(host_busy), .host_done(host_done)
);

// File: tb/dbt_ctrl_bench.sv
// Bench with a behavioural per-clock reference model compared every cycle.
module dbt_ctrl_bench;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [1:0]  req_width = 0;
    logic [31:0] req_wdata = 0;
    logic [3:0]  t_cs2wr = 0, t_first = 0, t_next = 0, t_wact = 0, t_whigh = 0;
    logic        dev_ready_n = 0;
    logic [31:0] dev_rdata = 32'h1234_5679;
    logic        dev_cs_n, dev_rd_n, dev_wr_n, host_busy, host_done;
    logic [31:0] dev_wdata, host_rdata;
    logic [1:0]  dev_beat;

    int    checks = 0, errors = 0, cycles = 0;
    string cur = "R1";
    bit    rnd_en = 0;
    logic  rdy_fixed = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_P/2) clk = ~clk;

    dbt_ctrl u_dbt_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_width(req_width), .req_wdata(req_wdata), .t_cs2wr(t_cs2wr),
        .t_first(t_first), .t_next(t_next), .t_wact(t_wact), .t_whigh(t_whigh),
        .dev_ready_n(dev_ready_n), .dev_rdata(dev_rdata), .dev_cs_n(dev_cs_n),
        .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_wdata(dev_wdata),
        .dev_beat(dev_beat), .host_busy(host_busy), .host_done(host_done),
        .host_rdata(host_rdata)
    );

    // ---------------- reference model ----------------
    int m_mode = 0, m_cnt = 0, m_beat = 0, m_nb = 1, m_bw = 32, m_w = 0;
    logic [31:0] m_wd = 0, m_rd = 0;
    bit m_done = 0, m_seen_done = 0;

    function automatic int mx(input int v, input int m);
        return (v < m) ? m : v;
    endfunction

    always @(posedge clk) begin
        int len, gap;
        bit ign, fin;
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_beat = 0; m_done = 0; m_rd = 0;
        end else begin
            m_done = 0;
            case (m_mode)
                0: if (req_valid) begin
                    m_w    = int'(req_width);
                    m_nb   = (m_w == 0) ? 4 : (m_w == 1) ? 2 : 1;
                    m_bw   = (m_w == 0) ? 8 : (m_w == 1) ? 16 : 32;
                    m_wd   = req_wdata;
                    m_rd   = 0;
                    m_beat = 0; m_cnt = 0;
                    m_mode = req_write ? 2 : 1;
                end
                1, 3: begin
                    if (m_mode == 1) begin
                        len = (m_beat == 0) ? mx(int'(t_first), 1) + 2 : int'(t_next) + 2;
                        ign = (m_beat == 0) ? (t_first <= 1) : (t_next == 0);
                    end else begin
                        len = int'(t_wact) + 2;
                        ign = (t_wact == 0);
                    end
                    if (m_cnt < len - 1) m_cnt++;
                    else if (ign || !dev_ready_n) begin
                        if (m_mode == 1)
                            m_rd = m_rd | ((32'(dev_rdata) & 32'((64'd1 << m_bw) - 1)) << (m_beat * m_bw));
                        fin = (m_beat == m_nb - 1);
                        m_cnt = 0;
                        if (fin) begin m_mode = 0; m_done = 1; end
                        else if (m_mode == 1) m_beat++;
                        else begin
                            gap = mx(int'(t_whigh), (m_w < 2) ? 1 : 0);
                            if (gap == 0) m_beat++; else m_mode = 4;
                        end
                    end
                end
                2: begin
                    len = mx(int'(t_cs2wr), 1) + 2;
                    if (m_cnt < len - 1) m_cnt++;
                    else begin m_cnt = 0; m_mode = 3; end
                end
                4: begin
                    gap = mx(int'(t_whigh), (m_w < 2) ? 1 : 0);
                    if (m_cnt < gap - 1) m_cnt++;
                    else begin m_cnt = 0; m_mode = 3; m_beat++; end
                end
                default: m_mode = 0;
            endcase
            if (m_done) m_seen_done = 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) t=%0t: got %h exp %h", tag, cur, $time, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the sampling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 cs_n", 32'(dev_cs_n), 32'(m_mode == 0));
            chk("R11 busy", 32'(host_busy), 32'(m_mode != 0));
            chk("R6 rd_n", 32'(dev_rd_n), 32'(m_mode != 1));
            chk("R3 wr_n", 32'(dev_wr_n), 32'(m_mode != 3));
            chk("R10 done", 32'(host_done), 32'(m_done));
            if (m_mode == 3)
                chk("R7 wdata", dev_wdata, 32'((64'(m_wd) >> (m_beat * m_bw)) & ((64'd1 << m_bw) - 1)));
            if (m_done)
                chk("R7 rdata", host_rdata, m_rd);
        end
    end

    // Ready and device data generation.
    always @(negedge clk) begin
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        dev_ready_n <= rnd_en ? (lfsr[0] & lfsr[3]) : rdy_fixed;
        dev_rdata <= {dev_rdata[30:0], dev_rdata[31] ^ dev_rdata[21] ^ dev_rdata[1] ^ dev_rdata[0]};
    end

    task automatic run(input string tag, input bit wr, input logic [1:0] w,
                       input logic [31:0] wd, input logic [3:0] c, input logic [3:0] f,
                       input logic [3:0] n, input logic [3:0] a, input logic [3:0] h,
                       input bit rnd);
        int k;
        cur = tag;
        @(negedge clk);
        t_cs2wr = c; t_first = f; t_next = n; t_wact = a; t_whigh = h;
        rnd_en = rnd; req_write = wr; req_width = w; req_wdata = wd;
        m_seen_done = 0;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        k = 0;
        while (!m_seen_done && k < 2000) begin @(negedge clk); k++; end
        if (!m_seen_done) begin
            errors++; checks++;
            $display("FAIL watchdog (%s): got busy exp done", tag);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cs_n", 32'(dev_cs_n), 32'd1);
        chk("R1 rd_n", 32'(dev_rd_n), 32'd1);
        chk("R1 wr_n", 32'(dev_wr_n), 32'd1);
        chk("R1 done", 32'(host_done), 32'd0);
        chk("R1 busy", 32'(host_busy), 32'd0);
        rst_n = 1;
        @(negedge clk);
        // R2 R4: 32-bit read, stretched by ready.
        run("R2 R4 rd32", 0, 2'd2, 32'h0, 4'd2, 4'd3, 4'd1, 4'd1, 4'd0, 1);
        // R5 R9: minimum phases ignore ready; t_first 0 treated as 1.
        run("R5 R9 rd8 min", 0, 2'd0, 32'h0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 1);
        // R6 R4: 16-bit read with later cycles stretched.
        run("R6 R4 rd16", 0, 2'd1, 32'h0, 4'd1, 4'd2, 4'd2, 4'd0, 4'd0, 1);
        run("R6 rd8 slow", 0, 2'd0, 32'h0, 4'd1, 4'd4, 4'd3, 4'd0, 4'd0, 0);
        run("R6 width3", 0, 2'd3, 32'h0, 4'd1, 4'd1, 4'd0, 4'd0, 4'd0, 0);
        // R3 R9: 32-bit write, setup clamped.
        run("R3 R9 wr32", 1, 2'd2, 32'hDEAD_BEEF, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0, 1);
        // R8 R7: 8-bit write, gap clamped to 1, ready stretches strobe.
        run("R8 R7 wr8", 1, 2'd0, 32'hA1B2_C3D4, 4'd2, 4'd1, 4'd0, 4'd2, 4'd0, 1);
        run("R8 wr16 gap", 1, 2'd1, 32'h5566_7788, 4'd1, 4'd1, 4'd0, 4'd0, 4'd3, 1);
        run("R8 wr32 nogap", 1, 2'd2, 32'h0F0F_1234, 4'd3, 4'd1, 4'd0, 4'd3, 4'd0, 0);
        // R11: requests while busy ignored; held request re-accepted.
        cur = "R11 held";
        t_first = 4'd2; t_next = 4'd1; req_write = 0; req_width = 2'd1; rnd_en = 1;
        req_valid = 1;
        repeat (60) @(negedge clk);
        req_valid = 0;
        repeat (40) @(negedge clk);
        run("R10 final rd8", 0, 2'd0, 32'h0, 4'd1, 4'd2, 4'd1, 4'd0, 4'd0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Global watchdog.
    initial begin
        wait (cycles > 150000);
        errors++; checks++;
        $display("FAIL watchdog: got hung exp finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule